// File: doc/BRIEF.md
# NFC-A Tag Load-Modulation Encoder

This block turns a tag response into the Type A load-modulation pattern on one output pin. It runs on the system clock and advances only on a clock-enable pulse that arrives once per 13.56 MHz carrier cycle. Eight enable pulses make one half-period of the 847.5 kHz subcarrier, which is the carrier divided by 16. Sixteen of these half-phases make one symbol. There are three symbol shapes. The first one modulates during its early half. The second one modulates during its late half. The third one stays quiet for the whole symbol.

A frame is sent when the caller pulses `start` while the block is idle. The frame is a quiet lead-in symbol, a start symbol of the first shape, the payload, and a quiet closing symbol. The payload has two forms. The first form is a run of whole bytes, each followed by its parity bit. The second form is a short frame of fewer than eight bits with no parity. The block presents a byte index on `byte_addr`. The caller answers on `data_in` and `par_in` from its own storage. The block reads both inputs only at the end of a symbol, and it has moved the index at least one full symbol before that read.

Top module: `nfc_a_tag_tx`

## Requirements
- R1: After reset, `busy` is 0, `mod_out` is 0 and `byte_addr` is 0.
- R2: Each half-phase lasts exactly 8 accepted `ce` pulses, and each symbol lasts 16 half-phases. Clock cycles with `ce` low do not advance the waveform.
- R3: The mark symbol drives `mod_out` high on half-phases 0, 2, 4 and 6, and low on every other half-phase. It is used for the start symbol and for a logic 1.
- R4: The space symbol drives `mod_out` high on half-phases 8, 10, 12 and 14, and low on every other half-phase. It is used for a logic 0.
- R5: The quiet symbol keeps `mod_out` low for all 16 half-phases. It is used for the lead-in and for the closing symbol.
- R6: A frame is sent in this order: one quiet symbol, one mark symbol (start), the payload, one quiet symbol. When `nbits` is 0 the payload is empty.
- R7: When `nbits` is 8 or more, floor(`nbits`/8) bytes are sent and the low three bits of `nbits` are ignored. Each byte goes out LSB first, followed by one parity symbol.
- R8: When `nbits` is 1 to 7, bits 0 to `nbits`-1 of byte 0 are sent LSB first, with no parity symbol.
- R9: The caller supplies data byte `byte_addr` on `data_in` and parity byte `byte_addr`>>3 on `par_in`. The parity of byte i is bit 7-(i mod 8) of that parity byte.
- R10: `busy` rises on the clock edge that accepts `start`. It falls on the edge that consumes the last `ce` pulse of the closing symbol, which is 128 times the number of symbols in `ce` pulses after acceptance.
- R11: A `start` pulse while `busy` is 1 is ignored. The frame in flight and its length do not change, and no new frame follows it.
- R12: `mod_out` is low whenever the block is idle, and at the end of every symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | One pulse per carrier cycle |
| start | input | 1 | Request to send a frame; accepted only when idle |
| nbits | input | $clog2(MAX_BYTES*8+1) | Frame length in bits, sampled on acceptance |
| data_in | input | 8 | Data byte at index `byte_addr` |
| par_in | input | 8 | Packed parity byte at index `byte_addr`>>3 |
| byte_addr | output | $clog2(MAX_BYTES) | Index of the byte the block needs next |
| busy | output | 1 | High while a frame is being sent |
| mod_out | output | 1 | Load-modulation drive |

## Verification
On every cycle, the assertions check the following:
- The timer holds still when `ce` is low.
- Each symbol shape stays quiet in the half it must not modulate.
- The output is low while idle.
- `byte_addr` stays within the frame.
- `busy` falls only at the end of the closing symbol.
- A start pulse during a frame leaves the latched length unchanged.

Only the bench scenarios can show the symbol order across a whole frame. This covers LSB-first data, the parity-bit selection across more than one parity byte, the short-frame and empty-frame cases, and the exact frame duration in enable pulses. The bench checks these with an irregular enable pattern.

// File: rtl/nfc_a_tx_pkg.sv
package nfc_a_tx_pkg;
  // symbol shapes
  typedef enum logic [1:0] {
    SYM_QUIET  = 2'd0,
    SYM_MARK   = 2'd1,
    SYM_SPACE  = 2'd2
  } sym_t;

  // frame sequencer states
  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_LEAD = 3'd1,
    ST_SOF  = 3'd2,
    ST_DATA = 3'd3,
    ST_PAR  = 3'd4,
    ST_TAIL = 3'd5
  } st_t;
endpackage

// File: rtl/nfc_a_tx_timer.sv
module nfc_a_tx_timer #(
  parameter int HALF_TICKS = 8,
  parameter int SYM_HALVES = 16,
  localparam int TICK_W = $clog2(HALF_TICKS),
  localparam int HALF_W = $clog2(SYM_HALVES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              clr,
  input  logic              run,
  output logic [HALF_W-1:0] half,
  output logic              sym_end
);
  logic [TICK_W-1:0] tick;
  logic tick_last, half_last;

  assign tick_last = (tick == TICK_W'(HALF_TICKS - 1));
  assign half_last = (half == HALF_W'(SYM_HALVES - 1));
  assign sym_end   = run && ce && tick_last && half_last;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      tick <= '0;
      half <= '0;
    end else if (run && ce) begin
      if (tick_last) begin
        tick <= '0;
        half <= half_last ? '0 : half + 1'b1;
      end else begin
        tick <= tick + 1'b1;
      end
    end
  end

  // R2: no progress without a carrier pulse
  assert_hold_no_ce_R2: assert property (@(posedge clk) disable iff (rst)
    (run && !ce && !clr) |=> ($stable(half) && $stable(tick)));
  // R2: half-phase index moves only on the last tick of a half-phase
  assert_half_step_R2: assert property (@(posedge clk) disable iff (rst)
    (run && ce && !clr && !tick_last) |=> $stable(half));
endmodule

// File: rtl/nfc_a_tx_shaper.sv
module nfc_a_tx_shaper
  import nfc_a_tx_pkg::*;
#(
  parameter int SYM_HALVES = 16,
  localparam int HALF_W = $clog2(SYM_HALVES),
  localparam int MID    = SYM_HALVES / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  sym_t              sym,
  input  logic [HALF_W-1:0] half,
  output logic              mod_out
);
  logic early;
  assign early = (half < HALF_W'(MID));

  always_ff @(posedge clk) begin
    if (rst) begin
      mod_out <= 1'b0;
    end else begin
      unique case (sym)
        SYM_MARK:  mod_out <= busy && early && !half[0];
        SYM_SPACE: mod_out <= busy && !early && !half[0];
        default:   mod_out <= 1'b0;
      endcase
    end
  end

  assert_mark_late_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (sym == SYM_MARK && half >= HALF_W'(MID)) |=> !mod_out);
  assert_space_early_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (sym == SYM_SPACE && half < HALF_W'(MID)) |=> !mod_out);
  assert_quiet_sym_R5: assert property (@(posedge clk) disable iff (rst)
    (sym == SYM_QUIET) |=> !mod_out);
  assert_idle_low_R12: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !mod_out);
endmodule

// File: rtl/nfc_a_tx_seq.sv
module nfc_a_tx_seq
  import nfc_a_tx_pkg::*;
#(
  parameter int MAX_BYTES = 32,
  localparam int BITS_W = $clog2(MAX_BYTES * 8 + 1),
  localparam int ADDR_W = $clog2(MAX_BYTES),
  localparam int NB_W   = BITS_W - 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BITS_W-1:0] nbits,
  input  logic [7:0]        data_in,
  input  logic [7:0]        par_in,
  input  logic              sym_end,
  output logic              accept,
  output logic              busy,
  output sym_t              sym,
  output logic [ADDR_W-1:0] byte_addr
);
  st_t               state;
  logic [BITS_W-1:0] nbits_q;
  logic [2:0]        bit_i;
  logic [7:0]        shreg;
  logic              pbit, more;
  logic              short_f;
  logic [NB_W-1:0]   nbytes, next_cnt;
  logic [2:0]        par_pos;

  assign busy     = (state != ST_OFF);
  assign accept   = start && !busy;
  assign short_f  = (nbits_q[BITS_W-1:3] == '0);
  assign nbytes   = nbits_q[BITS_W-1:3];
  assign next_cnt = NB_W'(byte_addr) + NB_W'(1);
  assign par_pos  = 3'd7 - byte_addr[2:0];

  always_comb begin
    unique case (state)
      ST_SOF:  sym = SYM_MARK;
      ST_DATA: sym = shreg[0] ? SYM_MARK : SYM_SPACE;
      ST_PAR:  sym = pbit ? SYM_MARK : SYM_SPACE;
      default: sym = SYM_QUIET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_OFF;
      nbits_q   <= '0;
      bit_i     <= '0;
      shreg     <= '0;
      pbit      <= 1'b0;
      more      <= 1'b0;
      byte_addr <= '0;
    end else if (accept) begin
      state     <= ST_LEAD;
      nbits_q   <= nbits;
      bit_i     <= '0;
      byte_addr <= '0;
    end else if (sym_end) begin
      unique case (state)
        ST_LEAD: state <= ST_SOF;
        ST_SOF: begin
          if (nbits_q == '0) begin
            state <= ST_TAIL;
          end else begin
            state <= ST_DATA;
            shreg <= data_in;
            pbit  <= par_in[par_pos];
            bit_i <= '0;
          end
        end
        ST_DATA: begin
          if (short_f) begin
            if (bit_i == nbits_q[2:0] - 3'd1) begin
              state <= ST_TAIL;
            end else begin
              bit_i <= bit_i + 1'b1;
              shreg <= shreg >> 1;
            end
          end else if (bit_i == 3'd7) begin
            state <= ST_PAR;
            if (next_cnt != nbytes) begin
              more      <= 1'b1;
              byte_addr <= byte_addr + 1'b1;
            end else begin
              more <= 1'b0;
            end
          end else begin
            bit_i <= bit_i + 1'b1;
            shreg <= shreg >> 1;
          end
        end
        ST_PAR: begin
          if (more) begin
            state <= ST_DATA;
            shreg <= data_in;
            pbit  <= par_in[par_pos];
            bit_i <= '0;
          end else begin
            state <= ST_TAIL;
          end
        end
        ST_TAIL: state <= ST_OFF;
        default: state <= ST_OFF;
      endcase
    end
  end

  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> $stable(nbits_q));
  assert_busy_fall_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(sym_end) && $past(state) == ST_TAIL));
  assert_addr_bound_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && !short_f) |-> (NB_W'(byte_addr) < nbytes));
endmodule

// File: rtl/nfc_a_tag_tx.sv
module nfc_a_tag_tx
  import nfc_a_tx_pkg::*;
#(
  parameter int MAX_BYTES  = 32,
  parameter int HALF_TICKS = 8,
  parameter int SYM_HALVES = 16,
  localparam int BITS_W = $clog2(MAX_BYTES * 8 + 1),
  localparam int ADDR_W = $clog2(MAX_BYTES),
  localparam int HALF_W = $clog2(SYM_HALVES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              start,
  input  logic [BITS_W-1:0] nbits,
  input  logic [7:0]        data_in,
  input  logic [7:0]        par_in,
  output logic [ADDR_W-1:0] byte_addr,
  output logic              busy,
  output logic              mod_out
);
  logic              accept, sym_end;
  logic [HALF_W-1:0] half;
  sym_t              sym;

  nfc_a_tx_timer #(.HALF_TICKS(HALF_TICKS), .SYM_HALVES(SYM_HALVES)) u_timer (
    .clk(clk), .rst(rst), .ce(ce), .clr(accept), .run(busy),
    .half(half), .sym_end(sym_end)
  );

  nfc_a_tx_seq #(.MAX_BYTES(MAX_BYTES)) u_seq (
    .clk(clk), .rst(rst), .start(start), .nbits(nbits),
    .data_in(data_in), .par_in(par_in), .sym_end(sym_end),
    .accept(accept), .busy(busy), .sym(sym), .byte_addr(byte_addr)
  );

  nfc_a_tx_shaper #(.SYM_HALVES(SYM_HALVES)) u_shaper (
    .clk(clk), .rst(rst), .busy(busy), .sym(sym), .half(half),
    .mod_out(mod_out)
  );
endmodule

// File: tb/sim_nfc_a_tag_tx.sv
module sim_nfc_a_tag_tx;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB   = 32;
  localparam int BITS_W = $clog2(MAXB * 8 + 1);
  localparam int ADDR_W = $clog2(MAXB);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b0;
  logic start = 1'b0;
  logic [BITS_W-1:0] nbits = '0;
  logic [7:0] data_in, par_in;
  logic [ADDR_W-1:0] byte_addr;
  logic busy, mod_out;

  logic [7:0] dmem [0:MAXB-1];
  logic [7:0] pmem [0:MAXB/8-1];

  int total = 0;
  int bad = 0;
  int k = 0;
  bit mon_on = 1'b0;
  bit smp = 1'b0;
  int half_idx = 0;
  string tag = "R1";
  logic expq [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign data_in = dmem[byte_addr];
  assign par_in  = pmem[byte_addr >> 3];

  nfc_a_tag_tx #(.MAX_BYTES(MAXB)) u0 (
    .clk(clk), .rst(rst), .ce(ce), .start(start), .nbits(nbits),
    .data_in(data_in), .par_in(par_in), .byte_addr(byte_addr),
    .busy(busy), .mod_out(mod_out)
  );

  // irregular carrier enable: two of every three cycles
  int ce_div = 0;
  always @(negedge clk) begin
    ce_div = (ce_div == 2) ? 0 : ce_div + 1;
    ce = (ce_div != 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: count enable pulses, sample mid half-phase
  always @(posedge clk) begin
    if (mon_on && ce) begin
      k++;
      if (k % 8 == 4) smp = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (smp) begin
      logic e;
      smp = 1'b0;
      total++;
      if (expq.size() == 0) begin
        bad++;
        $display("FAIL %s: half-phase %0d actual=%0b expected=none", tag, half_idx, mod_out);
      end else begin
        e = expq.pop_front();
        if (mod_out !== e) begin
          bad++;
          $display("FAIL %s: half-phase %0d actual=%0b expected=%0b", tag, half_idx, mod_out, e);
        end
      end
      half_idx++;
    end
  end

  // kind: 0 quiet (R5), 1 mark (R3), 2 space (R4)
  task automatic push_sym(input int kind);
    for (int h = 0; h < 16; h++) begin
      logic lv;
      if (kind == 1)      lv = (h < 8) && (h % 2 == 0);
      else if (kind == 2) lv = (h >= 8) && (h % 2 == 0);
      else                lv = 1'b0;
      expq.push_back(lv);
    end
  endtask

  task automatic push_bit(input logic b);
    push_sym(b ? 1 : 2);
  endtask

  task automatic run_frame(input int nb, input string t, input int poke_at);
    int nsym;
    int guard;
    tag = t;
    expq.delete();
    push_sym(0);          // R6 lead-in
    push_sym(1);          // R6 start symbol
    if (nb >= 8) begin    // R7 whole bytes, R9 parity choice
      for (int i = 0; i < nb / 8; i++) begin
        for (int b = 0; b < 8; b++) push_bit(dmem[i][b]);
        push_bit(pmem[i / 8][7 - (i % 8)]);
      end
    end else begin        // R8 short frame
      for (int b = 0; b < nb; b++) push_bit(dmem[0][b]);
    end
    push_sym(0);          // R6 closing
    nsym = expq.size() / 16;
    @(negedge clk);
    nbits = BITS_W'(nb);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    half_idx = 0;
    mon_on = 1'b1;
    chk(busy == 1'b1, "R10 busy after start", busy, 1);
    guard = 0;
    while (busy && guard < 60000) begin
      @(negedge clk);
      guard++;
      if (poke_at > 0 && guard == poke_at) begin
        nbits = BITS_W'(8);
        start = 1'b1;   // R11 must be ignored
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    mon_on = 1'b0;
    chk(k == nsym * 128, {t, " R10 frame length in ce"}, k, nsym * 128);
    chk(expq.size() == 0, {t, " R6 symbols left"}, expq.size(), 0);
    chk(mod_out == 1'b0, "R12 idle output", mod_out, 0);
    repeat (20) @(negedge clk);
    chk(busy == 1'b0, "R11 no follow-on frame", busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < MAXB; i++) dmem[i] = 8'((i * 37 + 11) ^ (i << 3));
    for (int i = 0; i < MAXB / 8; i++) pmem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(mod_out == 1'b0, "R1 mod_out", mod_out, 0);
    chk(byte_addr == '0, "R1 byte_addr", byte_addr, 0);

    // R7 R3 R4 R2: four bytes, mixed parity
    dmem[0] = 8'hA5; dmem[1] = 8'h3C; dmem[2] = 8'hFF; dmem[3] = 8'h00;
    pmem[0] = 8'b1010_0000;
    run_frame(32, "R7 four bytes", 0);

    // R8: short frame of 3 bits, bits 1,0,1
    dmem[0] = 8'b1111_0101;
    run_frame(3, "R8 short", 0);

    // R6: empty frame
    run_frame(0, "R6 empty", 0);

    // R9: nine bytes, parity of byte 8 from parity byte 1 bit 7
    for (int i = 0; i < 9; i++) dmem[i] = 8'(8'h5A + i * 19);
    pmem[0] = 8'b0110_1001;
    pmem[1] = 8'b1000_0000;
    run_frame(72, "R9 nine bytes", 0);
    pmem[1] = 8'b0000_0000;
    run_frame(72, "R9 nine bytes clear", 0);

    // R7: length 13 sends one byte only
    dmem[0] = 8'h81; pmem[0] = 8'b0000_0000;
    run_frame(13, "R7 low bits ignored", 0);

    // R11: start pulse in the middle of a frame
    dmem[0] = 8'hC3; dmem[1] = 8'h18; pmem[0] = 8'b1100_0000;
    run_frame(16, "R11 start while busy", 700);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule